// File: doc/BRIEF.md
# Dual-Spacer Dual-Rail Encoder Stage

This stage takes single-rail words from a valid/ready source and drives them onto a dual-rail bus. Each bit has two wires. While a word is shown, one wire carries the bit and the other carries its complement. Between two words the bus always returns to a null state, called a spacer. The spacer in which every wire is low and the spacer in which every wire is high take turns. Over a full cycle both wires of every bit switch the same number of times, whatever the data is, so the switching activity does not depend on the values carried.

The downstream side gives back a single acknowledge level. A high level requests data and a low level requests null. The stage moves to its next phase only when the acknowledge matches that phase. The block is synchronous logic that models the clockless protocol cycle by cycle. The rail outputs come straight from registers, so no glitch or partial word ever appears on the bus.

Top module: `dsdr_encoder`

## Requirements
- R1: While reset is held low and in the first cycle after it is released, both `rail0_o` and `rail1_o` are all zeros (the all-zero spacer). In that state `in_ready_o` equals `ack_i`.
- R2: A word accepted at a clock edge appears on the next cycle with `rail1_o` equal to the word and `rail0_o` equal to its bitwise complement. For example, word 0x02 gives `rail0_o` = 0xFD.
- R3: A word is accepted only when `in_valid_i` and `in_ready_o` are both high. `in_ready_o` is high only while a spacer is driven and `ack_i` is 1 (request for data).
- R4: While a word is shown and `ack_i` stays 1, the rails hold that word. At the first edge at which `ack_i` is 0 (request for null), the rails change to a spacer on the next cycle.
- R5: The spacer type changes after every word. The first spacer after reset is all-zero, the spacer after the first word is all-one, the next one is all-zero, and so on.
- R6: No bit is ever in a mixed state. In a data phase every bit has exactly one rail high. In a spacer phase every rail of every bit carries the same level.
- R7: While a spacer is driven and `ack_i` is 0, `in_valid_i` is ignored: `in_ready_o` stays low and the rails keep the spacer.
- R8: Changes on `in_data_i` during a data phase do not change the word shown on the rails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | W | Single-rail word |
| in_valid_i | input | 1 | Word on `in_data_i` is valid |
| in_ready_o | output | 1 | Stage accepts a word this cycle |
| ack_i | input | 1 | Downstream acknowledge: 1 requests data, 0 requests null |
| rail0_o | output | W | Zero rail of each bit |
| rail1_o | output | W | One rail of each bit |

## Verification
The bench runs each word through a full data–null exchange and tracks which spacer type is due. A design that never toggles the spacer type, or that toggles it at reset, shows the wrong level in the second or first spacer. The bench holds `ack_i` high after data arrives and changes `in_data_i` at the same time, which catches a stage that returns to null too early or passes the input straight through. It also raises `in_valid_i` while null is being requested and while data is shown, which catches a stage that takes a second word without a spacer in between.

// File: rtl/dsdr_pkg.sv
package dsdr_pkg;
  typedef enum logic {
    PH_SPACER = 1'b0,
    PH_DATA   = 1'b1
  } phase_e;
endpackage

// File: rtl/dsdr_phase_ctrl.sv
module dsdr_phase_ctrl
  import dsdr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   valid_i,
  input  logic   ack_i,
  output logic   ready_o,
  output logic   load_o,
  output logic   retire_o,
  output logic   fill_o,
  output phase_e phase_o
);
  phase_e phase_q;
  logic   spc_q;  // level of the spacer most recently driven

  assign ready_o  = (phase_q == PH_SPACER) && ack_i;
  assign load_o   = ready_o && valid_i;
  assign retire_o = (phase_q == PH_DATA) && !ack_i;
  assign fill_o   = ~spc_q;
  assign phase_o  = phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_SPACER;
      spc_q   <= 1'b0;
    end else if (load_o) begin
      phase_q <= PH_DATA;
    end else if (retire_o) begin
      phase_q <= PH_SPACER;
      spc_q   <= ~spc_q;
    end
  end
endmodule

// File: rtl/dsdr_rail_bit.sv
module dsdr_rail_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic retire_i,
  input  logic fill_i,
  input  logic d_i,
  output logic r0_o,
  output logic r1_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r0_o <= 1'b0;
      r1_o <= 1'b0;
    end else if (load_i) begin
      r0_o <= ~d_i;
      r1_o <= d_i;
    end else if (retire_i) begin
      r0_o <= fill_i;
      r1_o <= fill_i;
    end
  end
endmodule

// File: rtl/dsdr_encoder.sv
module dsdr_encoder
  import dsdr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_data_i,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic         ack_i,
  output logic [W-1:0] rail0_o,
  output logic [W-1:0] rail1_o
);
  logic   load, retire, fill;
  phase_e phase;

  dsdr_phase_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (in_valid_i),
    .ack_i    (ack_i),
    .ready_o  (in_ready_o),
    .load_o   (load),
    .retire_o (retire),
    .fill_o   (fill),
    .phase_o  (phase)
  );

  for (genvar b = 0; b < W; b++) begin : g_bit
    dsdr_rail_bit u_bit (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load),
      .retire_i (retire),
      .fill_i   (fill),
      .d_i      (in_data_i[b]),
      .r0_o     (rail0_o[b]),
      .r1_o     (rail1_o[b])
    );
  end
endmodule

// File: rtl/dsdr_encoder_chk.sv
module dsdr_encoder_chk
  import dsdr_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] in_data_i,
  input logic         in_valid_i,
  input logic         in_ready_o,
  input logic         ack_i,
  input logic [W-1:0] rail0_o,
  input logic [W-1:0] rail1_o,
  input phase_e       phase
);
  logic last_spc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 last_spc_q <= 1'b0;
    else if (phase == PH_SPACER) last_spc_q <= rail0_o[0];
  end

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (rail1_o == $past(in_data_i)) && (rail0_o == ~$past(in_data_i)));

  p_ready_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ready_o |-> (phase == PH_SPACER) && ack_i);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_DATA && ack_i) |=> $stable(rail0_o) && $stable(rail1_o));

  p_alternate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_DATA && !ack_i) |=> (rail0_o == {W{~$past(last_spc_q)}}));

  p_no_mixed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_DATA) |-> ((rail0_o ^ rail1_o) == {W{1'b1}}));

  p_spacer_uniform_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_SPACER) |-> (rail0_o == rail1_o) && (rail0_o == '0 || rail0_o == '1));

  p_null_ignore_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_SPACER && !ack_i) |=> $stable(rail0_o) && $stable(rail1_o));
endmodule

bind dsdr_encoder dsdr_encoder_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_data_i  (in_data_i),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .ack_i      (ack_i),
  .rail0_o    (rail0_o),
  .rail1_o    (rail1_o),
  .phase      (phase)
);

// File: tb/dsdr_encoder_bench.sv
`timescale 1ns/1ps
module dsdr_encoder_bench;
  localparam int unsigned W = 8;
  localparam int NV = 8;
  // {word, expected rail0}
  localparam logic [15:0] VEC [NV] = '{
    16'h02_FD, 16'h00_FF, 16'hFF_00, 16'hA5_5A,
    16'h5A_A5, 16'h01_FE, 16'h80_7F, 16'h3C_C3
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_valid = 1'b0;
  logic         ack = 1'b0;
  logic         in_ready;
  logic [W-1:0] rail0, rail1;
  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  dsdr_encoder #(.W(W)) u_dsdr_encoder (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_valid_i(in_valid),
    .in_ready_o(in_ready), .ack_i(ack), .rail0_o(rail0), .rail1_o(rail1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic spc;
    // R1 reset state
    #5;
    chk("R1 rail0 in reset", 32'(rail0), 32'h0);
    chk("R1 rail1 in reset", 32'(rail1), 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rail0 after reset", 32'(rail0), 32'h0);
    chk("R1 ready with ack low", 32'(in_ready), 32'h0);
    ack = 1'b1;
    #1;
    chk("R1 ready follows ack", 32'(in_ready), 32'h1);
    ack = 1'b0;

    spc = 1'b0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_data = VEC[i][15:8]; in_valid = 1'b1; ack = 1'b1;
      #1;
      chk("R3 ready in spacer with rfd", 32'(in_ready), 32'h1);
      @(negedge clk);
      chk("R2 rail1 data", 32'(rail1), 32'(VEC[i][15:8]));
      chk("R2 rail0 data", 32'(rail0), 32'(VEC[i][7:0]));
      chk("R3 ready low in data", 32'(in_ready), 32'h0);
      in_data = ~VEC[i][15:8];  // R8 disturbance, valid still high
      @(negedge clk);
      chk("R4 R8 rail1 held", 32'(rail1), 32'(VEC[i][15:8]));
      chk("R4 R8 rail0 held", 32'(rail0), 32'(VEC[i][7:0]));
      ack = 1'b0;
      @(negedge clk);
      spc = ~spc;
      chk("R5 R6 rail0 spacer", 32'(rail0), {24'h0, {W{spc}}});
      chk("R5 R6 rail1 spacer", 32'(rail1), {24'h0, {W{spc}}});
      chk("R7 ready low on rfn", 32'(in_ready), 32'h0);
      in_data = 8'h77;
      @(negedge clk);
      chk("R7 rail0 unchanged", 32'(rail0), {24'h0, {W{spc}}});
      chk("R7 rail1 unchanged", 32'(rail1), {24'h0, {W{spc}}});
      in_valid = 1'b0;
    end

    // R1 reset during data phase returns to all-zero spacer, first spacer after is all-one
    @(negedge clk);
    in_data = 8'h12; in_valid = 1'b1; ack = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R1 async reset rail1", 32'(rail1), 32'h0);
    chk("R1 async reset rail0", 32'(rail0), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    in_data = 8'h34; in_valid = 1'b1; ack = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 data after reset", 32'(rail0), 32'h0CB);
    ack = 1'b0;
    @(negedge clk);
    chk("R5 first spacer all-one", 32'(rail0 & rail1), 32'h0FF);

    finish_run();
  end
endmodule